// File: doc/BRIEF.md
# Programmable Staircase Level Generator

This block produces a digital staircase for a DAC or a downstream signal path. A prescaler counts system clock cycles and issues a step tick once per programmed tick period. On each tick an unsigned level register takes a programmable step. When the new level would rise above a programmable ceiling, the level drops to zero and the ramp starts again. A one-cycle pulse marks each wrap.

The wrap decision compares the sum with the ceiling and selects between them. No modulo or divide logic is used. The sum carries one extra bit, so a large step cannot fold back silently. With a 40 MHz system clock, a tick period of 4000 gives a 10 kHz step rate. The step size is set apart from that rate, so each step can be a large jump.

Top module: `staircase_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `level_o` and `wrap_o` become 0 and the prescaler is cleared. The period value present during reset is captured as the first tick period.
- R2: With `en` high and a captured period P ≥ 1, the level updates on every P-th enabled clock edge and holds in between. P = 0 behaves as P = 1, which means a tick on every enabled edge.
- R3: On a tick, the new level is `level_o + step_i`, computed 17 bits wide. A sum that exceeds the 16-bit range is never truncated, and a nonzero level never exceeds the `max_i` value sampled on that tick.
- R4: On a tick whose sum is strictly greater than `max_i`, `level_o` becomes 0 and `wrap_o` is 1 in that same cycle. In every other cycle `wrap_o` is 0.
- R5: While `en` is low, the level and the prescaler hold their values and `wrap_o` is 0.
- R6: A new `period_i` value is captured only at a tick. The interval that is already running finishes with the old period, and the next interval uses the new value.
- R7: With `step_i` = 0 and `level_o` ≤ `max_i`, the level stays constant.
- R8: With `max_i` = 0, a level of 0 stays at 0.
- R9: A sum exactly equal to `max_i` is kept as the new level and does not cause a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes prescaler and level |
| step_i | input | 16 | Unsigned step added on each tick |
| max_i | input | 16 | Unsigned ceiling; sums above it wrap to 0 |
| period_i | input | 16 | Clock cycles per tick, captured at each tick |
| level_o | output | 16 | Current staircase level (registered) |
| wrap_o | output | 1 | One-cycle pulse when the level returns to 0 |

## Verification
The ramp is driven with these stimuli:
- A step that divides the ceiling evenly, which separates a sum equal to the ceiling (kept) from a sum one step above it (wrapped).
- An uneven step with a multi-cycle period.
- A step so large that the sum leaves the 16-bit range. This exposes a missing carry bit.
- A tick period of 4000, with the gap between level changes measured directly.
- A period change in mid-interval, which shows whether the new value is applied only at the tick boundary.
- A period of 0.
- A frozen enable.
- A zero step.
- A zero ceiling.

// File: rtl/stair_pkg.sv
package stair_pkg;
  parameter int unsigned STAIR_LVL_W = 16;
  parameter int unsigned STAIR_PER_W = 16;
endpackage

// File: rtl/stair_tick.sv
module stair_tick #(
  parameter int unsigned PW = stair_pkg::STAIR_PER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] last_cnt;

  // a zero period is treated as one cycle per tick
  always_comb begin
    if (per_q == '0) last_cnt = '0;
    else             last_cnt = per_q - 1'b1;
  end

  assign tick_o = en && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= period_i;
    end else if (tick_o) begin
      cnt_q <= '0;
      per_q <= period_i;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stair_accum.sv
module stair_accum #(
  parameter int unsigned W = stair_pkg::STAIR_LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] level_o,
  output logic         wrap_o
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] sum_w;
  logic          over_w;

  assign sum_w  = {1'b0, level_o} + {1'b0, step_i};
  assign over_w = sum_w > {1'b0, max_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= '0;
      wrap_o  <= 1'b0;
    end else if (tick_i) begin
      level_o <= over_w ? '0 : sum_w[W-1:0];
      wrap_o  <= over_w;
    end else begin
      wrap_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/staircase_gen.sv
module staircase_gen #(
  parameter int unsigned W  = stair_pkg::STAIR_LVL_W,
  parameter int unsigned PW = stair_pkg::STAIR_PER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  step_i,
  input  logic [W-1:0]  max_i,
  input  logic [PW-1:0] period_i,
  output logic [W-1:0]  level_o,
  output logic          wrap_o
);
  logic tick_w;

  stair_tick #(.PW(PW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .period_i (period_i),
    .tick_o   (tick_w)
  );

  stair_accum #(.W(W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_w),
    .step_i  (step_i),
    .max_i   (max_i),
    .level_o (level_o),
    .wrap_o  (wrap_o)
  );
endmodule

// File: rtl/staircase_gen_chk.sv
module staircase_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] step_i,
  input logic [W-1:0] max_i,
  input logic [W-1:0] level_o,
  input logic         wrap_o
);
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (level_o == '0));

  p_hold_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(level_o) && !wrap_o));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(level_o) && level_o != '0) |->
      ({1'b0, level_o} == {1'b0, $past(level_o)} + {1'b0, $past(step_i)}));

  p_within_max_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(level_o) && level_o != '0) |-> (level_o <= $past(max_i)));

  p_zero_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i == '0 && level_o <= max_i) |=> $stable(level_o));

  p_zero_max_r8: assert property (@(posedge clk) disable iff (rst)
    (max_i == '0 && level_o == '0) |=> (level_o == '0));
endmodule

bind staircase_gen staircase_gen_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .step_i  (step_i),
  .max_i   (max_i),
  .level_o (level_o),
  .wrap_o  (wrap_o)
);

// File: tb/staircase_gen_bench.sv
module staircase_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] step_i = '0;
  logic [15:0] max_i = '0;
  logic [15:0] period_i = 16'd3;
  logic [15:0] level_o;
  logic        wrap_o;

  int total = 0;
  int bad = 0;

  int m_cnt = 0, m_per = 0, m_lvl = 0, m_wrap = 0;

  staircase_gen u_staircase_gen (
    .clk(clk), .rst(rst), .en(en), .step_i(step_i), .max_i(max_i),
    .period_i(period_i), .level_o(level_o), .wrap_o(wrap_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int last, s;
    if (rst) begin
      m_cnt = 0; m_per = period_i; m_lvl = 0; m_wrap = 0;
    end else if (en) begin
      last = (m_per == 0) ? 0 : m_per - 1;
      if (m_cnt == last) begin
        m_cnt = 0;
        m_per = period_i;
        s = m_lvl + step_i;
        if (s > max_i) begin m_lvl = 0; m_wrap = 1; end
        else begin m_lvl = s; m_wrap = 0; end
      end else begin
        m_cnt++;
        m_wrap = 0;
      end
    end else begin
      m_wrap = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 R3 R6 level", level_o, m_lvl);
      check("R4 wrap", wrap_o, m_wrap);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int snap, seen_max, seen_wrap, gap;
    logic [15:0] prev;

    run(5);
    rst = 1'b0;
    @(negedge clk);
    check("R1 level after reset", level_o, 0);
    check("R1 wrap after reset", wrap_o, 0);

    // R9: even step into ceiling
    step_i = 16'd10; max_i = 16'd30; period_i = 16'd1; en = 1'b1;
    run(4);  // finish prior period-3 interval
    seen_max = 0; seen_wrap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (level_o == 16'd30) seen_max = 1;
      if (wrap_o) seen_wrap = 1;
    end
    check("R9 level equal to max reached", seen_max, 1);
    check("R4 wrap pulse seen", seen_wrap, 1);

    // uneven step, multi-cycle period
    step_i = 16'd7; max_i = 16'd50; period_i = 16'd3;
    run(40);

    // period change mid-interval
    period_i = 16'd5; run(32);
    period_i = 16'd2; run(21);

    // period zero
    period_i = 16'd0; step_i = 16'd1; max_i = 16'd1000; run(10);

    // R5: enable low freezes
    en = 1'b0; @(negedge clk); snap = level_o;
    run(10);
    check("R5 level held with en low", level_o, snap);
    check("R5 no wrap with en low", wrap_o, 0);
    en = 1'b1;

    // R7: zero step
    step_i = 16'd0; max_i = 16'd1000; @(negedge clk); snap = level_o;
    run(20);
    check("R7 level constant with zero step", level_o, snap);

    // R8: zero ceiling
    step_i = 16'd5; max_i = 16'd0; run(3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 level stays 0 with max 0", level_o, 0);
    end

    // R3: sum beyond 16 bits must wrap, not fold
    step_i = 16'd40000; max_i = 16'd65535; period_i = 16'd2; run(20);

    // R2: measured tick spacing at 4000 cycles
    step_i = 16'd1000; max_i = 16'd60000; period_i = 16'd4000;
    for (int k = 0; k < 2; k++) begin
      prev = level_o;
      for (int t = 0; t < 9000 && level_o == prev; t++) @(negedge clk);
    end
    prev = level_o; gap = 0;
    for (int t = 0; t < 9000 && level_o == prev; t++) begin
      @(negedge clk);
      gap++;
    end
    check("R2 cycles between steps at period 4000", gap, 4000);

    finish_run();
  end
endmodule